// File: doc/BRIEF.md
# Non-restoring division step unit

This block computes a binary division one quotient bit at a time. It keeps a 32-bit working word that holds the partial remainder and the collected quotient bits. It also keeps three status bits: Q (the remainder-sign bit), M (the divisor-sign bit) and T (the latest quotient bit). Each step shifts the working word left and feeds the current T in at the bottom. It then adds the divisor to the word or subtracts it, depending on Q and M, and forms new Q and T values. Every new quotient bit enters the word through T, so no separate quotient register exists.

Before a division the surrounding logic loads the working word and issues one of two setup commands. The unsigned setup clears the status bits. The signed setup takes the signs of the dividend and the divisor. After that, single steps can be issued one per cycle. A built-in sequencer can also run a fixed number of steps back to back after one start pulse and flag the end with a one-cycle done pulse. With the default of 16 steps, a 16-bit unsigned dividend in the low half of the word and the divisor placed in the upper half of the divisor input give the quotient as the low 15 bits of the word followed by T.

Top module: `divstep_unit`

## Requirements
- R1: After reset, word_o, q_o, m_o, t_o, busy_o, done_o and err_o are all 0.
- R2: A step uses the old Q and the current M. If they are equal, the divisor is subtracted from {word[30:0], T}; otherwise it is added. The new Q is word[31] XOR carry XOR M. The carry is the borrow for a subtraction and the carry out for an addition.
- R3: After every step, T is 1 exactly when the new Q equals M.
- R4: An unsigned setup (init_uns_i) clears Q, M and T in the next cycle.
- R5: A signed setup (init_sgn_i) sets Q to word_i[31] and M to divisor_i[31]. T becomes Q XOR M. When both setup inputs are high, the signed setup is applied.
- R6: load_i writes word_i into the working word. When step_i is high in the same cycle, the step is dropped and Q, M and T keep their values.
- R7: step_i high together with a setup input is illegal. The setup is applied, the working word is unchanged, and err_o is high for exactly the next cycle.
- R8: A start_i pulse while idle, with no other command, raises busy_o in the next cycle. The unit then runs STEPS steps, one per clock, with the divisor captured at the start. done_o pulses for one cycle as busy_o falls. For a 16-bit unsigned dividend a and divisor b (b ≠ 0) with divisor_i = b << 16, the result {word_o[14:0], t_o} equals a / b.
- R9: While busy_o is high, load_i, step_i, start_i, both setup inputs and changes of divisor_i have no effect. M holds its value and err_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_i | input | 32 | Word to load; bit 31 gives the dividend sign for the signed setup |
| divisor_i | input | 32 | Divisor operand; bit 31 gives its sign for the signed setup |
| load_i | input | 1 | Load word_i into the working word |
| init_uns_i | input | 1 | Unsigned setup: clear Q, M and T |
| init_sgn_i | input | 1 | Signed setup from the operand signs |
| step_i | input | 1 | Perform one division step |
| start_i | input | 1 | Run the STEPS-step sequence |
| word_o | output | 32 | Working word (partial remainder and quotient bits) |
| q_o | output | 1 | Q status bit |
| m_o | output | 1 | M status bit |
| t_o | output | 1 | T status bit, latest quotient bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last sequenced step |
| err_o | output | 1 | One-cycle pulse after an illegal step-with-setup |

## Verification
The checker tests these rules on every cycle:
- T agrees with Q and M after every step.
- Bit 0 of a single step's result is the old T XOR divisor bit 0.
- Both setups produce the correct flags.
- A load reaches the word.
- The error pulse is raised exactly when it should be, and at no other time.
- The done pulse is one cycle long and falls with busy.
- M never moves outside a setup.

The full step arithmetic needs the bench's case-table model. That covers the add/subtract choice, the carry and the new Q across mixed sign patterns. The quotient of a whole sequence, the exact step count, and the rule that commands given mid-run are ignored can only be shown by the bench's scenarios.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  // Operation applied to the Q/M/T status bits this cycle
  typedef enum logic [1:0] {
    FLG_HOLD   = 2'd0,
    FLG_CLEAR  = 2'd1,
    FLG_SIGNED = 2'd2,
    FLG_STEP   = 2'd3
  } flag_op_e;

  // Operation applied to the working word this cycle
  typedef enum logic [1:0] {
    WRD_HOLD = 2'd0,
    WRD_LOAD = 2'd1,
    WRD_STEP = 2'd2
  } word_op_e;

  // Result of one division step
  typedef struct packed {
    logic q;
    logic t;
  } step_flags_t;

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu
  import divstep_pkg::*;
#(
  parameter int W          = 32,
  parameter int ALU_RIPPLE = 0
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] divisor_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  output logic [W-1:0] word_o,
  output step_flags_t  flags_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] shifted;
  logic [W-1:0] sum;
  logic         sub;
  logic         cy;   // borrow on subtract, carry out on add

  assign shifted = {word_i[MSB-1:0], t_i};
  assign sub     = (q_i == m_i);

  generate
    if (ALU_RIPPLE != 0) begin : g_ripple
      logic [W:0]   c;
      logic [W-1:0] b;
      assign b    = sub ? ~divisor_i : divisor_i;
      assign c[0] = sub;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]   = shifted[i] ^ b[i] ^ c[i];
        assign c[i+1]   = (shifted[i] & b[i]) | (c[i] & (shifted[i] ^ b[i]));
      end
      assign cy = sub ? ~c[W] : c[W];
    end else begin : g_wide
      logic [W:0] ext;
      assign ext = sub ? ({1'b0, shifted} - {1'b0, divisor_i})
                       : ({1'b0, shifted} + {1'b0, divisor_i});
      assign sum = ext[W-1:0];
      assign cy  = ext[W];
    end
  endgenerate

  always_comb begin
    word_o    = sum;
    flags_o.q = word_i[MSB] ^ cy ^ m_i;
    flags_o.t = (flags_o.q == m_i);
  end

endmodule

// File: rtl/divstep_decode.sv
module divstep_decode
  import divstep_pkg::*;
(
  input  logic     busy_i,
  input  logic     load_i,
  input  logic     init_uns_i,
  input  logic     init_sgn_i,
  input  logic     step_i,
  input  logic     start_i,
  output flag_op_e flag_op_o,
  output word_op_e word_op_o,
  output logic     seq_go_o,
  output logic     err_o
);

  logic any_init;

  assign any_init = init_uns_i | init_sgn_i;

  always_comb begin
    flag_op_o = FLG_HOLD;
    word_op_o = WRD_HOLD;
    seq_go_o  = 1'b0;
    err_o     = 1'b0;
    if (busy_i) begin
      // sequencer owns the datapath; every external command is dropped
      flag_op_o = FLG_STEP;
      word_op_o = WRD_STEP;
    end else begin
      if (init_sgn_i) begin
        flag_op_o = FLG_SIGNED;
      end else if (init_uns_i) begin
        flag_op_o = FLG_CLEAR;
      end else if (step_i && !load_i) begin
        flag_op_o = FLG_STEP;
      end

      if (load_i) begin
        word_op_o = WRD_LOAD;
      end else if (step_i && !any_init) begin
        word_op_o = WRD_STEP;
      end

      seq_go_o = start_i & ~any_init & ~load_i & ~step_i;
      err_o    = step_i & any_init;
    end
  end

endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
  parameter int W     = 32,
  parameter int STEPS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] divisor_o
);

  localparam int                CW   = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0]     LAST = CW'(STEPS - 1);

  logic          busy_q, busy_nx;
  logic          done_q, done_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [W-1:0]  dvsr_q;
  logic          dvsr_en;
  logic          cnt_en;

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    done_nx = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_nx = 1'b0;
        done_nx = 1'b1;
        cnt_nx  = '0;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end else if (go_i) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
    end
  end

  assign dvsr_en = go_i & ~busy_q;
  assign cnt_en  = busy_q | go_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
      if (cnt_en) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dvsr_en) begin
      dvsr_q <= divisor_i;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign divisor_o = dvsr_q;

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int W          = 32,
  parameter int STEPS      = 16,
  parameter int ALU_RIPPLE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] divisor_i,
  input  logic         load_i,
  input  logic         init_uns_i,
  input  logic         init_sgn_i,
  input  logic         step_i,
  input  logic         start_i,
  output logic [W-1:0] word_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);

  localparam int MSB = W - 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_n_s = rst_pipe[1];

  flag_op_e     flag_op;
  word_op_e     word_op;
  logic         seq_go;
  logic         err_nx;
  logic         busy;
  logic         done;
  logic [W-1:0] dvsr_lat;
  logic [W-1:0] dvsr_sel;

  logic [W-1:0] word_q, word_nx, step_word;
  logic         q_q, m_q, t_q;
  logic         q_nx, m_nx, t_nx;
  logic         err_q;
  logic         word_en, flag_en, m_en;
  step_flags_t  step_flags;

  divstep_decode u_decode (
    .busy_i     (busy),
    .load_i     (load_i),
    .init_uns_i (init_uns_i),
    .init_sgn_i (init_sgn_i),
    .step_i     (step_i),
    .start_i    (start_i),
    .flag_op_o  (flag_op),
    .word_op_o  (word_op),
    .seq_go_o   (seq_go),
    .err_o      (err_nx)
  );

  divstep_seq #(
    .W     (W),
    .STEPS (STEPS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go_i      (seq_go),
    .divisor_i (divisor_i),
    .busy_o    (busy),
    .done_o    (done),
    .divisor_o (dvsr_lat)
  );

  assign dvsr_sel = busy ? dvsr_lat : divisor_i;

  divstep_alu #(
    .W          (W),
    .ALU_RIPPLE (ALU_RIPPLE)
  ) u_alu (
    .word_i    (word_q),
    .divisor_i (dvsr_sel),
    .q_i       (q_q),
    .m_i       (m_q),
    .t_i       (t_q),
    .word_o    (step_word),
    .flags_o   (step_flags)
  );

  // next-state: status bits
  always_comb begin
    q_nx = q_q;
    m_nx = m_q;
    t_nx = t_q;
    unique case (flag_op)
      FLG_CLEAR: begin
        q_nx = 1'b0;
        m_nx = 1'b0;
        t_nx = 1'b0;
      end
      FLG_SIGNED: begin
        q_nx = word_i[MSB];
        m_nx = divisor_i[MSB];
        t_nx = word_i[MSB] ^ divisor_i[MSB];
      end
      FLG_STEP: begin
        q_nx = step_flags.q;
        t_nx = step_flags.t;
      end
      default: ;
    endcase
  end

  // next-state: working word
  always_comb begin
    word_nx = word_q;
    unique case (word_op)
      WRD_LOAD: word_nx = word_i;
      WRD_STEP: word_nx = step_word;
      default:  ;
    endcase
  end

  assign word_en = (word_op != WRD_HOLD);
  assign flag_en = (flag_op != FLG_HOLD);
  assign m_en    = (flag_op == FLG_CLEAR) || (flag_op == FLG_SIGNED);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      word_q <= '0;
      q_q    <= 1'b0;
      m_q    <= 1'b0;
      t_q    <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (word_en) begin
        word_q <= word_nx;
      end
      if (flag_en) begin
        q_q <= q_nx;
        t_q <= t_nx;
      end
      if (m_en) begin
        m_q <= m_nx;
      end
      err_q <= err_nx;
    end
  end

  assign word_o = word_q;
  assign q_o    = q_q;
  assign m_o    = m_q;
  assign t_o    = t_q;
  assign busy_o = busy;
  assign done_o = done;
  assign err_o  = err_q;

endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] word_i,
  input logic [W-1:0] divisor_i,
  input logic         load_i,
  input logic         init_uns_i,
  input logic         init_sgn_i,
  input logic         step_i,
  input logic         start_i,
  input logic [W-1:0] word_o,
  input logic         q_o,
  input logic         m_o,
  input logic         t_o,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o
);

  logic any_init;
  logic lone_step;
  logic bad_cmd;

  assign any_init  = init_uns_i | init_sgn_i;
  assign lone_step = !busy_o && step_i && !load_i && !any_init;
  assign bad_cmd   = !busy_o && step_i && any_init;

  // R2: bit 0 of a lone step is old T xor divisor bit 0 (add and subtract alike)
  p_step_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lone_step |=> (word_o[0] == ($past(t_o) ^ $past(divisor_i[0]))));

  // R3: T reflects Q == M after every step
  p_t_tracks_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || lone_step) |=> (t_o == (q_o == m_o)));

  // R4
  p_uinit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && init_uns_i && !init_sgn_i) |=> (!q_o && !m_o && !t_o));

  // R5
  p_sinit_signs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && init_sgn_i) |=>
      ((q_o == $past(word_i[W-1])) && (m_o == $past(divisor_i[W-1])) && (t_o != (q_o == m_o))));

  // R6
  p_load_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && load_i) |=> (word_o == $past(word_i)));

  // R7
  p_err_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> err_o);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_cmd |=> !err_o);

  // R8
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: M only moves on a setup accepted while idle
  p_m_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || !any_init) |=> $stable(m_o));

endmodule

bind divstep_unit divstep_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .word_i     (word_i),
  .divisor_i  (divisor_i),
  .load_i     (load_i),
  .init_uns_i (init_uns_i),
  .init_sgn_i (init_sgn_i),
  .step_i     (step_i),
  .start_i    (start_i),
  .word_o     (word_o),
  .q_o        (q_o),
  .m_o        (m_o),
  .t_o        (t_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/divstep_unit_tb.sv
module divstep_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 16;
  localparam int NVEC       = 8;

  // {dividend[15:0], divisor[15:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd1,     16'd1},
    {16'd100,   16'd7},
    {16'hFFFF,  16'hFFFF},
    {16'hFFFF,  16'd1},
    {16'd0,     16'd5},
    {16'd12345, 16'd321},
    {16'd6,     16'd7},
    {16'hABCD,  16'h8001}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] word_i, divisor_i;
  logic        load_i, init_uns_i, init_sgn_i, step_i, start_i;
  logic [31:0] word_o;
  logic        q_o, m_o, t_o, busy_o, done_o, err_o;

  int n_chk;
  int n_bad;
  bit finished;

  divstep_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_i     (word_i),
    .divisor_i  (divisor_i),
    .load_i     (load_i),
    .init_uns_i (init_uns_i),
    .init_sgn_i (init_sgn_i),
    .step_i     (step_i),
    .start_i    (start_i),
    .word_o     (word_o),
    .q_o        (q_o),
    .m_o        (m_o),
    .t_o        (t_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cmds();
    load_i     = 1'b0;
    init_uns_i = 1'b0;
    init_sgn_i = 1'b0;
    step_i     = 1'b0;
    start_i    = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Bench model of one step, written from the case tables
  task automatic model_step(input logic [31:0] w, input logic [31:0] d,
                            input logic q, input logic m, input logic t,
                            output logic [31:0] nw, output logic nq, output logic nt);
    logic [31:0] sh;
    logic        flag;
    sh = {w[30:0], t};
    if (q == m) begin
      nw   = sh - d;
      flag = (nw > sh);
    end else begin
      nw   = sh + d;
      flag = (nw < sh);
    end
    if (!m) nq = w[31] ? !flag : flag;
    else    nq = w[31] ? flag : !flag;
    nt = (nq == m);
  endtask

  // Load and set up, then run single steps against the model
  task automatic single_run(input logic [31:0] w, input logic [31:0] d,
                            input bit sgn, input int nsteps);
    logic [31:0] ew;
    logic        eq, em, et;
    word_i    = w;
    divisor_i = d;
    load_i    = 1'b1;
    if (sgn) init_sgn_i = 1'b1;
    else     init_uns_i = 1'b1;
    tick();
    idle_cmds();
    ew = w;
    eq = sgn ? w[31] : 1'b0;
    em = sgn ? d[31] : 1'b0;
    et = eq ^ em;
    chk("R6 load word", word_o, ew);
    if (sgn) begin
      chk("R5 signed Q", {31'd0, q_o}, {31'd0, eq});
      chk("R5 signed M", {31'd0, m_o}, {31'd0, em});
      chk("R5 signed T", {31'd0, t_o}, {31'd0, et});
    end else begin
      chk("R4 unsigned QMT", {29'd0, q_o, m_o, t_o}, 32'd0);
    end
    for (int k = 0; k < nsteps; k++) begin
      model_step(ew, d, eq, em, et, ew, eq, et);
      step_i = 1'b1;
      tick();
      step_i = 1'b0;
      chk("R2 step word", word_o, ew);
      chk("R2 step Q",    {31'd0, q_o}, {31'd0, eq});
      chk("R3 step T",    {31'd0, t_o}, {31'd0, et});
      chk("R9 M held over step", {31'd0, m_o}, {31'd0, em});
    end
  endtask

  // Unsigned 16-bit division through the sequencer
  task automatic run_div(input logic [15:0] a, input logic [15:0] b);
    int n;
    word_i     = {16'd0, a};
    divisor_i  = {b, 16'd0};
    load_i     = 1'b1;
    init_uns_i = 1'b1;
    tick();
    idle_cmds();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R8 busy after start", {31'd0, busy_o}, 32'd1);
    n = 0;
    while (!done_o && n < 40) begin
      tick();
      n++;
    end
    chk("R8 step count", n, STEPS);
    chk("R8 busy falls with done", {31'd0, busy_o}, 32'd0);
    chk("R8 quotient", {16'd0, word_o[14:0], t_o}, {16'd0, a / b});
    tick();
    chk("R8 done single pulse", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] hold_w;
    int n;
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    word_i    = '0;
    divisor_i = '0;
    idle_cmds();
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1: reset state
    chk("R1 reset word", word_o, 32'd0);
    chk("R1 reset flags", {25'd0, q_o, m_o, t_o, busy_o, done_o, err_o}, 32'd0);

    // Table of sequenced divisions (R8)
    for (int i = 0; i < NVEC; i++) begin
      run_div(VEC[i][31:16], VEC[i][15:0]);
    end

    // Single steps with several sign patterns (R2, R3, R4, R5, R6)
    single_run(32'h8000_1234, 32'h0003_0000, 1'b1, 4);
    single_run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4);
    single_run(32'hF000_0001, 32'h9000_0000, 1'b0, 4);
    single_run(32'hC123_4567, 32'h8765_4321, 1'b1, 3);

    // R5: both setups together, signed applied
    word_i     = 32'h8000_0000;
    divisor_i  = 32'h8000_0000;
    init_uns_i = 1'b1;
    init_sgn_i = 1'b1;
    tick();
    idle_cmds();
    chk("R5 signed wins QMT", {29'd0, q_o, m_o, t_o}, {29'd0, 3'b110});

    // R6: load with step drops the step
    word_i = 32'h1357_9BDF;
    load_i = 1'b1;
    step_i = 1'b1;
    tick();
    idle_cmds();
    chk("R6 load beats step word", word_o, 32'h1357_9BDF);
    chk("R6 load beats step QMT", {29'd0, q_o, m_o, t_o}, {29'd0, 3'b110});

    // R7: step with setup
    hold_w     = word_o;
    word_i     = 32'hDEAD_BEEF;
    step_i     = 1'b1;
    init_uns_i = 1'b1;
    tick();
    idle_cmds();
    chk("R7 word unchanged", word_o, hold_w);
    chk("R7 setup applied", {29'd0, q_o, m_o, t_o}, 32'd0);
    chk("R7 err raised", {31'd0, err_o}, 32'd1);
    tick();
    chk("R7 err one cycle", {31'd0, err_o}, 32'd0);

    // R9: commands during a run are ignored, divisor captured at start
    word_i     = {16'd0, 16'd100};
    divisor_i  = {16'd7, 16'd0};
    load_i     = 1'b1;
    init_uns_i = 1'b1;
    tick();
    idle_cmds();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    repeat (4) tick();
    word_i     = 32'h8000_0000;
    divisor_i  = 32'hFFFF_FFFF;
    load_i     = 1'b1;
    init_sgn_i = 1'b1;
    step_i     = 1'b1;
    start_i    = 1'b1;
    tick();
    idle_cmds();
    chk("R9 M unchanged while busy", {31'd0, m_o}, 32'd0);
    chk("R9 no err while busy", {31'd0, err_o}, 32'd0);
    chk("R9 still busy", {31'd0, busy_o}, 32'd1);
    n = 0;
    while (!done_o && n < 40) begin
      tick();
      n++;
    end
    chk("R9 quotient unaffected", {16'd0, word_o[14:0], t_o}, 32'd14);
    tick();
    chk("R9 no restart", {31'd0, busy_o}, 32'd0);

    // R8: start together with step is not a start
    word_i  = 32'h0000_0003;
    start_i = 1'b1;
    step_i  = 1'b1;
    load_i  = 1'b1;
    tick();
    idle_cmds();
    chk("R8 start with other command ignored", {31'd0, busy_o}, 32'd0);

    finish_run();
  end

endmodule